// File: doc/BRIEF.md
# Multicycle Multiply-Accumulate Execution Unit

This unit carries out the multiply instructions of a processor execute stage. It multiplies two register values, optionally adds an accumulator, and returns either a single result word or a double-width result split into high and low words. The register file lives outside the block. The issuing logic passes in the operand values, the accumulator words and the register indices that the instruction names. The unit uses those indices only to decide whether the encoding is legal.

The modelled latency follows a multiplier array that stops early. The unit spends one to four array passes, depending on how many leading bytes of the second operand are pure sign extension. It adds one pass for the double-width form and one more for accumulation. While an operation is in flight `busy` stays high. `done` marks the single cycle in which the result and the negative/zero flag updates are presented.

Top module: `mac_exec_unit`

## Requirements
- R1: After reset, `busy`, `done`, `illegal`, `flag_n_we` and `flag_z_we` are all 0.
- R2: Register indices are 4 bits wide, and index 15 denotes the program counter. The operation is rejected when any of `dst_idx`, `acc_idx`, `mul_a_idx` or `mul_b_idx` equals 15. In the long form it is also rejected when `dst_lo_idx` equals 15. A rejected operation keeps `busy` high for one cycle and raises `done` and `illegal` together in the cycle after `start`. It writes no flags.
- R3: In the short form (`long_op`=0), `dst_idx` equal to `mul_a_idx` is rejected. In the long form the same pair is accepted, and `dst_lo_idx` equal to 15 is accepted in the short form.
- R4: Short form: `res_lo` is the low 32 bits of `op_a`×`op_b`, plus `acc_lo` (modulo 2^32) when `acc_op`=1. `res_hi` is 0.
- R5: Long form: `{res_hi,res_lo}` is the 64-bit product, computed as two's-complement when `signed_op`=1 and as unsigned otherwise. When `acc_op`=1, `{acc_hi,acc_lo}` is added modulo 2^64.
- R6: The latency is L = A + `long_op` + `acc_op`, where A is the array count. `busy` is high for exactly L cycles after the edge that samples `start`. `done` is high only in the last of those cycles.
- R7: The array count A is computed from `op_b`. A is 1 if bits 31..8 are all equal, otherwise 2 if bits 31..16 are all equal, otherwise 3 if bits 31..24 are all equal, otherwise 4.
- R8: When `setf_op`=1, `flag_n_we` and `flag_z_we` pulse with `done`. `flag_n` is the top bit of the result (bit 31 of `res_lo` in the short form, bit 31 of `res_hi` in the long form). `flag_z` is 1 when the whole result is zero. When `setf_op`=0 the enables stay low.
- R9: A `start` asserted while `busy` is high is ignored. It produces no completion and does not alter the result in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Issue an operation (taken when not busy) |
| long_op | input | 1 | 1 = double-width result |
| signed_op | input | 1 | 1 = two's-complement long product |
| acc_op | input | 1 | 1 = add accumulator |
| setf_op | input | 1 | 1 = update N and Z flags |
| dst_idx | input | 4 | Destination (high word in long form) register index |
| dst_lo_idx | input | 4 | Low-word destination index (long form) |
| acc_idx | input | 4 | Accumulator source register index |
| mul_a_idx | input | 4 | First multiplicand register index |
| mul_b_idx | input | 4 | Second multiplicand register index |
| op_a | input | 32 | First multiplicand value |
| op_b | input | 32 | Second multiplicand value (sets array count) |
| acc_lo | input | 32 | Accumulator low word / 32-bit accumulator |
| acc_hi | input | 32 | Accumulator high word (long form) |
| busy | output | 1 | Operation in flight |
| done | output | 1 | One-cycle completion strobe |
| illegal | output | 1 | Completion is a rejected encoding |
| res_lo | output | 32 | Result low word |
| res_hi | output | 32 | Result high word (0 in short form) |
| flag_n | output | 1 | Negative flag value |
| flag_z | output | 1 | Zero flag value |
| flag_n_we | output | 1 | Negative flag write enable |
| flag_z_we | output | 1 | Zero flag write enable |

## Verification
A new `start` can arrive in the same cycle as the completion of the operation in flight, or in any earlier busy cycle. The bench provokes this by issuing a long accumulating operation and pulsing `start` again one cycle later with an encoding that would be rejected. The scoreboard then expects exactly one completion, carrying the first operation's result, and no `illegal` strobe. Any extra completion, or a wrong value, is counted against R9.

// File: rtl/mac_pkg.sv
package mac_pkg;
   typedef enum logic [1:0] {
      MS_IDLE  = 2'd0,
      MS_RUN   = 2'd1,
      MS_FAULT = 2'd2
   } mac_state_e;
endpackage

// File: rtl/mac_reg_check.sv
module mac_reg_check #(
   parameter int IDX_W  = 4,
   parameter int PC_IDX = 15
) (
   input  logic             long_op,
   input  logic [IDX_W-1:0] dst_idx,
   input  logic [IDX_W-1:0] dst_lo_idx,
   input  logic [IDX_W-1:0] acc_idx,
   input  logic [IDX_W-1:0] mul_a_idx,
   input  logic [IDX_W-1:0] mul_b_idx,
   output logic             bad
);
   localparam logic [IDX_W-1:0] PC_CODE = IDX_W'(PC_IDX);

   logic uses_pc;
   logic overlap;

   always_comb begin
      uses_pc = (dst_idx == PC_CODE) || (acc_idx == PC_CODE) ||
                (mul_a_idx == PC_CODE) || (mul_b_idx == PC_CODE) ||
                (long_op && (dst_lo_idx == PC_CODE));
      overlap = !long_op && (dst_idx == mul_a_idx);
      bad     = uses_pc || overlap;
   end
endmodule

// File: rtl/mac_array_cycles.sv
module mac_array_cycles #(
   parameter int DATA_W  = 32,
   parameter int GROUP_W = 8,
   parameter int CNT_W   = 3
) (
   input  logic [DATA_W-1:0] op_b,
   output logic [CNT_W-1:0]  passes
);
   localparam int GROUPS = DATA_W / GROUP_W;

   // fits[k]: bits above k*GROUP_W are pure sign extension
   logic [GROUPS-1:0] fits;

   assign fits[0] = 1'b0;
   genvar k;
   generate
      for (k = 1; k < GROUPS; k++) begin : g_fit
         assign fits[k] = (&op_b[DATA_W-1:k*GROUP_W]) | ~(|op_b[DATA_W-1:k*GROUP_W]);
      end
   endgenerate

   always_comb begin
      passes = CNT_W'(GROUPS);
      for (int i = GROUPS - 1; i >= 1; i--) begin
         if (fits[i]) passes = CNT_W'(i);
      end
   end
endmodule

// File: rtl/mac_datapath.sv
module mac_datapath #(
   parameter int DATA_W = 32
) (
   input  logic              long_op,
   input  logic              signed_op,
   input  logic              acc_op,
   input  logic [DATA_W-1:0] op_a,
   input  logic [DATA_W-1:0] op_b,
   input  logic [DATA_W-1:0] acc_lo,
   input  logic [DATA_W-1:0] acc_hi,
   output logic [DATA_W-1:0] sum_lo,
   output logic [DATA_W-1:0] sum_hi,
   output logic              neg,
   output logic              zero
);
   localparam int WIDE_W = 2 * DATA_W;

   logic              ext_a;
   logic              ext_b;
   logic [WIDE_W-1:0] a_x;
   logic [WIDE_W-1:0] b_x;
   logic [WIDE_W-1:0] prod;
   logic [WIDE_W-1:0] acc_wide;
   logic [WIDE_W-1:0] wide_sum;
   logic [DATA_W-1:0] narrow_sum;

   // Sign-extending to the full width makes a modulo-2^(2W) product exact
   assign ext_a = signed_op & op_a[DATA_W-1];
   assign ext_b = signed_op & op_b[DATA_W-1];
   assign a_x   = {{DATA_W{ext_a}}, op_a};
   assign b_x   = {{DATA_W{ext_b}}, op_b};
   assign prod  = a_x * b_x;

   assign acc_wide   = acc_op ? {acc_hi, acc_lo} : '0;
   assign wide_sum   = prod + acc_wide;
   assign narrow_sum = prod[DATA_W-1:0] + (acc_op ? acc_lo : '0);

   always_comb begin
      if (long_op) begin
         sum_lo = wide_sum[DATA_W-1:0];
         sum_hi = wide_sum[WIDE_W-1:DATA_W];
         neg    = wide_sum[WIDE_W-1];
         zero   = (wide_sum == '0);
      end else begin
         sum_lo = narrow_sum;
         sum_hi = '0;
         neg    = narrow_sum[DATA_W-1];
         zero   = (narrow_sum == '0);
      end
   end
endmodule

// File: rtl/mac_exec_unit.sv
module mac_exec_unit #(
   parameter int DATA_W  = 32,
   parameter int IDX_W   = 4,
   parameter int PC_IDX  = 15,
   parameter int GROUP_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              long_op,
   input  logic              signed_op,
   input  logic              acc_op,
   input  logic              setf_op,
   input  logic [IDX_W-1:0]  dst_idx,
   input  logic [IDX_W-1:0]  dst_lo_idx,
   input  logic [IDX_W-1:0]  acc_idx,
   input  logic [IDX_W-1:0]  mul_a_idx,
   input  logic [IDX_W-1:0]  mul_b_idx,
   input  logic [DATA_W-1:0] op_a,
   input  logic [DATA_W-1:0] op_b,
   input  logic [DATA_W-1:0] acc_lo,
   input  logic [DATA_W-1:0] acc_hi,
   output logic              busy,
   output logic              done,
   output logic              illegal,
   output logic [DATA_W-1:0] res_lo,
   output logic [DATA_W-1:0] res_hi,
   output logic              flag_n,
   output logic              flag_z,
   output logic              flag_n_we,
   output logic              flag_z_we
);
   import mac_pkg::*;

   localparam int GROUPS = DATA_W / GROUP_W;
   localparam int CNT_W  = $clog2(GROUPS + 1);
   localparam int LAT_W  = $clog2(GROUPS + 3);

   generate
      if ((DATA_W % GROUP_W) != 0) begin : g_bad_group
         $error("DATA_W must be a multiple of GROUP_W");
      end
      if (GROUPS < 2) begin : g_bad_groups
         $error("at least two byte groups are required");
      end
      if (PC_IDX >= (1 << IDX_W)) begin : g_bad_pc
         $error("PC_IDX does not fit in IDX_W bits");
      end
   endgenerate

   logic              bad_c;
   logic [CNT_W-1:0]  passes_c;
   logic [DATA_W-1:0] sum_lo_c;
   logic [DATA_W-1:0] sum_hi_c;
   logic              neg_c;
   logic              zero_c;
   logic [LAT_W-1:0]  lat_c;

   mac_reg_check #(.IDX_W(IDX_W), .PC_IDX(PC_IDX)) u_regchk (
      .long_op    (long_op),
      .dst_idx    (dst_idx),
      .dst_lo_idx (dst_lo_idx),
      .acc_idx    (acc_idx),
      .mul_a_idx  (mul_a_idx),
      .mul_b_idx  (mul_b_idx),
      .bad        (bad_c)
   );

   mac_array_cycles #(.DATA_W(DATA_W), .GROUP_W(GROUP_W), .CNT_W(CNT_W)) u_arr (
      .op_b   (op_b),
      .passes (passes_c)
   );

   mac_datapath #(.DATA_W(DATA_W)) u_dp (
      .long_op   (long_op),
      .signed_op (signed_op),
      .acc_op    (acc_op),
      .op_a      (op_a),
      .op_b      (op_b),
      .acc_lo    (acc_lo),
      .acc_hi    (acc_hi),
      .sum_lo    (sum_lo_c),
      .sum_hi    (sum_hi_c),
      .neg       (neg_c),
      .zero      (zero_c)
   );

   assign lat_c = LAT_W'(passes_c) + LAT_W'(long_op) + LAT_W'(acc_op);

   mac_state_e       state_q;
   logic [LAT_W-1:0] left_q;
   logic             setf_q;
   logic             take;

   assign take = start && (state_q == MS_IDLE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= MS_IDLE;
         left_q  <= '0;
         setf_q  <= 1'b0;
         res_lo  <= '0;
         res_hi  <= '0;
         flag_n  <= 1'b0;
         flag_z  <= 1'b0;
      end else begin
         unique case (state_q)
            MS_IDLE: begin
               if (take) begin
                  setf_q <= setf_op;
                  if (bad_c) begin
                     state_q <= MS_FAULT;
                     left_q  <= '0;
                  end else begin
                     state_q <= MS_RUN;
                     left_q  <= lat_c - LAT_W'(1);
                     res_lo  <= sum_lo_c;
                     res_hi  <= sum_hi_c;
                     flag_n  <= neg_c;
                     flag_z  <= zero_c;
                  end
               end
            end
            MS_RUN: begin
               if (left_q == '0) state_q <= MS_IDLE;
               else              left_q  <= left_q - LAT_W'(1);
            end
            MS_FAULT: state_q <= MS_IDLE;
            default:  state_q <= MS_IDLE;
         endcase
      end
   end

   assign busy      = (state_q != MS_IDLE);
   assign illegal   = (state_q == MS_FAULT);
   assign done      = illegal || ((state_q == MS_RUN) && (left_q == '0));
   assign flag_n_we = done && !illegal && setf_q;
   assign flag_z_we = flag_n_we;
endmodule

// File: rtl/mac_exec_unit_chk.sv
module mac_exec_unit_chk #(
   parameter int DATA_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start,
   input logic              busy,
   input logic              done,
   input logic              illegal,
   input logic              flag_n_we,
   input logic              flag_z_we,
   input logic [DATA_W-1:0] res_lo,
   input logic [DATA_W-1:0] res_hi
);
   // R6
   done_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> busy);

   // R6
   done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R6
   launch_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy) |=> busy);

   // R2
   illegal_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      illegal |-> done);

   // R8
   flag_we_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_n_we || flag_z_we) |-> (done && !illegal));

   // R8
   flag_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
      flag_n_we |-> flag_z_we);

   // R9
   hold_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !done) |=> ($stable(res_lo) && $stable(res_hi)));
endmodule

bind mac_exec_unit mac_exec_unit_chk #(.DATA_W(DATA_W)) u_chk_sva (
   .clk       (clk),
   .rst_n     (rst_n),
   .start     (start),
   .busy      (busy),
   .done      (done),
   .illegal   (illegal),
   .flag_n_we (flag_n_we),
   .flag_z_we (flag_z_we),
   .res_lo    (res_lo),
   .res_hi    (res_hi)
);

// File: tb/sim_mac_exec_unit.sv
`timescale 1ns/1ps
module sim_mac_exec_unit;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic        long_op = 1'b0, signed_op = 1'b0, acc_op = 1'b0, setf_op = 1'b0;
   logic [3:0]  dst_idx = 4'd0, dst_lo_idx = 4'd0, acc_idx = 4'd0, mul_a_idx = 4'd0, mul_b_idx = 4'd0;
   logic [31:0] op_a = '0, op_b = '0, acc_lo = '0, acc_hi = '0;
   logic        busy, done, illegal, flag_n, flag_z, flag_n_we, flag_z_we;
   logic [31:0] res_lo, res_hi;

   always #10 clk = ~clk;

   mac_exec_unit u0 (
      .clk(clk), .rst_n(rst_n), .start(start), .long_op(long_op), .signed_op(signed_op),
      .acc_op(acc_op), .setf_op(setf_op), .dst_idx(dst_idx), .dst_lo_idx(dst_lo_idx),
      .acc_idx(acc_idx), .mul_a_idx(mul_a_idx), .mul_b_idx(mul_b_idx), .op_a(op_a),
      .op_b(op_b), .acc_lo(acc_lo), .acc_hi(acc_hi), .busy(busy), .done(done),
      .illegal(illegal), .res_lo(res_lo), .res_hi(res_hi), .flag_n(flag_n),
      .flag_z(flag_z), .flag_n_we(flag_n_we), .flag_z_we(flag_z_we)
   );

   typedef struct {
      string       tag;
      int          t0;
      int          lat;
      bit          ill;
      bit          we;
      bit          n;
      bit          z;
      logic [31:0] lo;
      logic [31:0] hi;
   } exp_t;

   exp_t exp_q[$];
   int   n_cmp = 0;
   int   n_bad = 0;
   int   cyc = 0;
   bit   finished = 0;

   always @(posedge clk) cyc <= cyc + 1;

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [63:0] act, input logic [63:0] expv);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, expv);
      end
   endtask

   function automatic int arr_passes(input logic [31:0] b);
      if (b[31:8] == 24'h0 || b[31:8] == 24'hFFFFFF) return 1;
      if (b[31:16] == 16'h0 || b[31:16] == 16'hFFFF) return 2;
      if (b[31:24] == 8'h0 || b[31:24] == 8'hFF) return 3;
      return 4;
   endfunction

   // Driver: compute expectation, push it, issue the operation
   task automatic run_op(input string tag, input bit lg, input bit sg, input bit ac, input bit sf,
                         input logic [3:0] d, input logic [3:0] dl, input logic [3:0] an,
                         input logic [3:0] ma, input logic [3:0] mb,
                         input logic [31:0] a, input logic [31:0] b,
                         input logic [31:0] al, input logic [31:0] ah);
      exp_t e;
      logic [63:0] w;
      logic [31:0] s;
      e.tag = tag;
      e.ill = (d == 4'd15) || (an == 4'd15) || (ma == 4'd15) || (mb == 4'd15) ||
              (lg && dl == 4'd15) || (!lg && d == ma);
      if (lg) begin
         if (sg) w = 64'($signed(a)) * 64'($signed(b));
         else    w = {32'h0, a} * {32'h0, b};
         if (ac) w = w + {ah, al};
         e.lo = w[31:0]; e.hi = w[63:32]; e.n = w[63]; e.z = (w == 64'h0);
      end else begin
         s = a * b;
         if (ac) s = s + al;
         e.lo = s; e.hi = 32'h0; e.n = s[31]; e.z = (s == 32'h0);
      end
      e.lat = e.ill ? 1 : arr_passes(b) + int'(lg) + int'(ac);
      e.we  = sf && !e.ill;
      @(negedge clk);
      long_op = lg; signed_op = sg; acc_op = ac; setf_op = sf;
      dst_idx = d; dst_lo_idx = dl; acc_idx = an; mul_a_idx = ma; mul_b_idx = mb;
      op_a = a; op_b = b; acc_lo = al; acc_hi = ah;
      start = 1'b1;
      e.t0 = cyc;
      exp_q.push_back(e);
      @(negedge clk);
      start = 1'b0;
   endtask

   task automatic wait_idle();
      while (busy) @(negedge clk);
      @(negedge clk);
   endtask

   // Monitor: pop and compare at each completion
   always @(negedge clk) begin
      if (rst_n && !finished) begin
         if (done) begin
            if (exp_q.size() == 0) begin
               chk(1'b0, "R9", "unexpected completion", 64'(illegal), 64'h0);
            end else begin
               exp_t e;
               e = exp_q.pop_front();
               chk((cyc - e.t0) == e.lat, "R6", {e.tag, " latency"}, 64'(cyc - e.t0), 64'(e.lat));
               chk(illegal == e.ill, e.ill ? "R2" : "R3", {e.tag, " illegal"}, 64'(illegal), 64'(e.ill));
               if (!e.ill) begin
                  chk({res_hi, res_lo} == {e.hi, e.lo}, "R4", {e.tag, " result (R4/R5)"},
                      {res_hi, res_lo}, {e.hi, e.lo});
               end
               chk(flag_n_we == e.we && flag_z_we == e.we, "R8", {e.tag, " flag enables"},
                   64'({flag_n_we, flag_z_we}), 64'({e.we, e.we}));
               if (e.we) begin
                  chk({flag_n, flag_z} == {e.n, e.z}, "R8", {e.tag, " N/Z"},
                      64'({flag_n, flag_z}), 64'({e.n, e.z}));
               end
            end
         end
      end
   end

   // Watchdog
   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         finished = 1;
         n_cmp++; n_bad++;
         $display("FAIL watchdog: actual hung expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk({busy, done, illegal, flag_n_we, flag_z_we} == 5'b0, "R1", "reset outputs",
          64'({busy, done, illegal, flag_n_we, flag_z_we}), 64'h0);

      // R4 / R7 short forms over the array-count boundaries
      run_op("short m1", 0, 0, 0, 1, 4'd1, 4'd0, 4'd2, 4'd3, 4'd4, 32'd1234, 32'h0000_00FF, 0, 0); wait_idle();
      run_op("short m1 neg", 0, 1, 0, 1, 4'd1, 4'd0, 4'd2, 4'd3, 4'd4, 32'd77, 32'hFFFF_FF80, 0, 0); wait_idle();
      run_op("short m2 R7", 0, 0, 0, 0, 4'd1, 4'd0, 4'd2, 4'd3, 4'd4, 32'h0001_0003, 32'h0000_1234, 0, 0); wait_idle();
      run_op("short m3 R7", 0, 0, 1, 1, 4'd5, 4'd0, 4'd2, 4'd3, 4'd4, 32'hDEAD_BEEF, 32'h0012_3456, 32'h1111_1111, 0); wait_idle();
      run_op("short m4 R7", 0, 0, 0, 1, 4'd5, 4'd0, 4'd2, 4'd3, 4'd4, 32'h0000_0003, 32'h8000_0000, 0, 0); wait_idle();
      run_op("short acc zero", 0, 0, 1, 1, 4'd5, 4'd0, 4'd2, 4'd3, 4'd4, 32'd5, 32'd3, 32'hFFFF_FFF1, 0); wait_idle();
      run_op("short dstlo15 ok", 0, 0, 0, 0, 4'd5, 4'd15, 4'd2, 4'd3, 4'd4, 32'd9, 32'd9, 0, 0); wait_idle();

      // R5 long forms
      run_op("long unsigned", 1, 0, 0, 1, 4'd1, 4'd2, 4'd3, 4'd4, 4'd5, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 0, 0); wait_idle();
      run_op("long signed", 1, 1, 0, 1, 4'd1, 4'd2, 4'd3, 4'd4, 4'd5, 32'hFFFF_FFFE, 32'h0000_7000, 0, 0); wait_idle();
      run_op("long signed acc", 1, 1, 1, 1, 4'd1, 4'd2, 4'd3, 4'd4, 4'd5, 32'h8000_0000, 32'h1234_5678, 32'h0000_0001, 32'h4000_0000); wait_idle();
      run_op("long acc to zero", 1, 0, 1, 1, 4'd1, 4'd2, 4'd3, 4'd4, 4'd5, 32'd2, 32'hFFFF_FFFF, 32'h0000_0002, 32'hFFFF_FFFE); wait_idle();
      run_op("long dst=mul_a ok R3", 1, 0, 0, 0, 4'd4, 4'd2, 4'd3, 4'd4, 4'd5, 32'd10, 32'd20, 0, 0); wait_idle();

      // R2 / R3 rejected encodings
      run_op("pc in mul_b R2", 0, 0, 0, 1, 4'd1, 4'd0, 4'd2, 4'd3, 4'd15, 32'd1, 32'd1, 0, 0); wait_idle();
      run_op("pc in dst_lo R2", 1, 0, 0, 1, 4'd1, 4'd15, 4'd2, 4'd3, 4'd4, 32'd1, 32'd1, 0, 0); wait_idle();
      run_op("pc in acc R2", 0, 0, 1, 0, 4'd1, 4'd0, 4'd15, 4'd3, 4'd4, 32'd1, 32'd1, 0, 0); wait_idle();
      run_op("short dst=mul_a R3", 0, 0, 0, 1, 4'd3, 4'd0, 4'd2, 4'd3, 4'd4, 32'd1, 32'd1, 0, 0); wait_idle();

      // R9 start while busy is ignored
      run_op("long acc before overlap", 1, 0, 1, 1, 4'd1, 4'd2, 4'd3, 4'd4, 4'd5, 32'h0F0F_0F0F, 32'h7654_3210, 32'h5, 32'h6);
      chk(busy == 1'b1, "R9", "busy during overlap", 64'(busy), 64'h1);
      mul_a_idx = 4'd15; op_b = 32'h0; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      wait_idle();
      repeat (3) @(negedge clk);
      chk(exp_q.size() == 0, "R9", "pending after overlap", 64'(exp_q.size()), 64'h0);
      chk(busy == 1'b0, "R9", "idle after overlap", 64'(busy), 64'h0);

      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule